// File: doc/BRIEF.md
# Idle Clock Throttling Controller

This block produces a per-cycle clock-enable strobe for a processing core. When the core is idle, meaning it waits for input samples or packets and has no encode or decode work in progress, and software has turned the feature on, the strobe is high in only one cycle out of four. The core then runs at a quarter of its normal rate. When work arrives, the strobe goes back to high on every cycle. Everything stays in one clock domain: the rate change is an enable pattern, not a gated or switched clock.

Software controls the feature through a small register-write port. Bit 4 of the power-save register at address 0x09 turns throttling on. A soft-reset strobe clears that bit and all other state, and so does the asynchronous active-low hard reset. A status output shows whether the quarter-rate pattern is in force at the moment. The rate is only lowered at a phase boundary of a free-running 2-bit counter, so the core never sees a partial enable period.

Top module: `idle_throttle_ctrl`

## Requirements
- R1: A write with address 0x09 loads the throttle enable from data bit 4. Writing 1 turns throttling on and writing 0 turns it off. A write to any other address leaves the enable unchanged.
- R2: While in quarter-rate mode, clkEn is high in exactly one cycle of every four: the first cycle of the mode and every fourth cycle after it.
- R3: If coreBusy is high at a clock edge, the mode after that edge is full rate (clkEn high), whatever the enable bit holds.
- R4: A softRst pulse clears the enable bit, the mode and the phase counter at the next edge. After it, the block stays at full rate until software sets the bit again.
- R5: While throttling is disabled, clkEn is high on every cycle.
- R6: Quarter-rate mode starts only at the edge where the 2-bit phase counter wraps from 3 to 0, and only if the enable is set, coreWaiting is high and coreBusy is low at that edge. The counter counts up by one on every cycle from reset.
- R7: If coreWaiting drops, or the enable is cleared while in quarter-rate mode, full rate returns at the next edge.
- R8: The throttled output is 1 exactly when quarter-rate mode is in force.
- R9: Driving rstN low at once forces full rate, with throttled at 0, the enable cleared and the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous soft reset strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 16 | Register write data |
| coreBusy | input | 1 | Core is encoding or decoding |
| coreWaiting | input | 1 | Core is waiting for samples or packets |
| clkEn | output | 1 | Per-cycle enable for the core |
| throttled | output | 1 | Quarter-rate mode in force |

## Verification
clkEn and throttled come straight from registers. Any input sampled at edge k therefore shows on the outputs in the cycle after edge k, with no further delay. The one exception is entry into quarter rate, which waits for the next counter wrap. The bench drives inputs on the falling edge. Its model takes one step per rising edge, using the same inputs. Both outputs are compared on the next falling edge, so every expected value belongs to exactly one rising edge.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic clrAll;     // soft reset: clear counter and mode
    logic goQuarter;  // enter quarter rate at this edge
    logic goFull;     // leave quarter rate at this edge
  } rateStrobes_t;

  typedef enum logic {
    MODE_FULL    = 1'b0,
    MODE_QUARTER = 1'b1
  } rateMode_e;

endpackage

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter logic [ADDR_W-1:0] PS_ADDR = 8'h09,
  parameter int EN_BIT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              coreBusy,
  input  logic              coreWaiting,
  input  logic              phaseWrap,
  input  logic              inQuarter,
  output rateStrobes_t      strobes
);

  logic enBitQ;
  logic psHit;
  logic idleWanted;
  logic unusedData;

  assign psHit      = wrEn && (wrAddr == PS_ADDR);
  assign unusedData = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        enBitQ <= 1'b0;
    else if (softRst) enBitQ <= 1'b0;
    else if (psHit)   enBitQ <= wrData[EN_BIT];
  end

  // The enable acts only after it has been stored in the register.
  assign idleWanted = enBitQ && coreWaiting && !coreBusy;

  always_comb begin
    strobes           = '0;
    strobes.clrAll    = softRst;
    strobes.goQuarter = !softRst && !inQuarter && idleWanted && phaseWrap;
    strobes.goFull    = !softRst && inQuarter && !idleWanted;
  end

  p_write_loads_r1: assert property (@(posedge clk) disable iff (!rstN)
    (psHit && !softRst) |=> (enBitQ == $past(wrData[EN_BIT])));

  p_other_addr_keeps_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!psHit && !softRst) |=> $stable(enBitQ));

  p_busy_full_rate_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreBusy |=> !inQuarter);

  p_soft_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!enBitQ && !inQuarter));

  p_disabled_no_throttle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enBitQ |=> !inQuarter);

  p_waiting_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    !coreWaiting |=> !inQuarter);

endmodule

// File: rtl/throttle_datapath.sv
module throttle_datapath
  import throttle_pkg::*;
#(
  parameter int RATE_LOG2 = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  rateStrobes_t strobes,
  output logic         phaseWrap,
  output logic         inQuarter,
  output logic         clkEn
);

  localparam int PH_W = RATE_LOG2;

  logic [PH_W-1:0] phaseQ;
  rateMode_e       modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseQ <= '0;
    else if (strobes.clrAll) phaseQ <= '0;
    else                     phaseQ <= phaseQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  modeQ <= MODE_FULL;
    else if (strobes.clrAll)    modeQ <= MODE_FULL;
    else if (strobes.goFull)    modeQ <= MODE_FULL;
    else if (strobes.goQuarter) modeQ <= MODE_QUARTER;
  end

  assign phaseWrap = &phaseQ;
  assign inQuarter = (modeQ == MODE_QUARTER);
  assign clkEn     = (modeQ == MODE_FULL) || (phaseQ == '0);

  p_counter_steps_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clrAll |=> (phaseQ == $past(phaseQ) + 1'b1));

  p_entry_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inQuarter) |-> clkEn);

  p_quarter_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inQuarter && $past(inQuarter) && $past(clkEn)) |-> !clkEn);

  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.goQuarter, strobes.goFull}));

endmodule

// File: rtl/idle_throttle_ctrl.sv
module idle_throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter logic [ADDR_W-1:0] PS_ADDR = 8'h09,
  parameter int EN_BIT    = 4,
  parameter int RATE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              coreBusy,
  input  logic              coreWaiting,
  output logic              clkEn,
  output logic              throttled
);

  rateStrobes_t strobes;
  logic         phaseWrap;
  logic         inQuarter;

  throttle_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PS_ADDR(PS_ADDR),
    .EN_BIT (EN_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .coreBusy   (coreBusy),
    .coreWaiting(coreWaiting),
    .phaseWrap  (phaseWrap),
    .inQuarter  (inQuarter),
    .strobes    (strobes)
  );

  throttle_datapath #(
    .RATE_LOG2(RATE_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .phaseWrap(phaseWrap),
    .inQuarter(inQuarter),
    .clkEn    (clkEn)
  );

  assign throttled = inQuarter;

endmodule

// File: tb/idle_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module idle_throttle_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        coreBusy = 1'b0;
  logic        coreWaiting = 1'b0;
  logic        clkEn;
  logic        throttled;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state, stepped from the requirements.
  logic       enM = 1'b0;
  logic       thrM = 1'b0;
  logic [1:0] phM = 2'd0;

  always #2.5 clk = ~clk;

  idle_throttle_ctrl u_dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .coreBusy(coreBusy),
    .coreWaiting(coreWaiting), .clkEn(clkEn), .throttled(throttled)
  );

  function automatic logic expEn();
    return !thrM || (phM == 2'd0);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic want;
    if (softRst) begin
      enM = 0; thrM = 0; phM = 0;
    end else begin
      want = enM && coreWaiting && !coreBusy;
      if (!want) thrM = 0;
      else if (phM == 2'd3) thrM = 1;
      phM = phM + 2'd1;
      if (wrEn && wrAddr == 8'h09) enM = wrData[4];
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(tag, "clkEn", clkEn, expEn());
    chk("R8", "throttled", throttled, thrM);
  endtask

  task automatic idleIn();
    softRst = 0; wrEn = 0; coreBusy = 0;
  endtask

  task automatic writeReg(logic [7:0] a, logic [15:0] d, string tag);
    wrEn = 1; wrAddr = a; wrData = d;
    cycle(tag);
    wrEn = 0;
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 0;
    enM = 0; thrM = 0; phM = 0;
    #1;
    chk("R9", "clkEn", clkEn, 1'b1);
    chk("R9", "throttled", throttled, 1'b0);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    hardReset();

    // R5: disabled, waiting, full rate every cycle
    coreWaiting = 1;
    for (int i = 0; i < 8; i++) cycle("R5");

    // R1: wrong address with bit 4 set is ignored
    writeReg(8'h0A, 16'h0010, "R1");
    for (int i = 0; i < 6; i++) cycle("R1");
    // R1: right address, bit 4 clear, other bits set
    writeReg(8'h09, 16'hFFEF, "R1");
    for (int i = 0; i < 6; i++) cycle("R1");
    // R1/R6/R2: enable, entry at wrap, then quarter pattern
    writeReg(8'h09, 16'h0010, "R1");
    for (int i = 0; i < 4; i++) cycle("R6");
    for (int i = 0; i < 12; i++) cycle("R2");
    chk("R2", "throttled steady", throttled, 1'b1);

    // R3: busy pulse forces full rate next cycle
    coreBusy = 1;
    cycle("R3");
    chk("R3", "clkEn after busy", clkEn, 1'b1);
    coreBusy = 0;
    for (int i = 0; i < 8; i++) cycle("R6");

    // R7: waiting drops
    coreWaiting = 0;
    cycle("R7");
    chk("R7", "full after waiting drop", throttled, 1'b0);
    coreWaiting = 1;
    for (int i = 0; i < 8; i++) cycle("R6");
    // R7: enable cleared while throttled
    writeReg(8'h09, 16'h0000, "R7");
    cycle("R7");
    chk("R7", "full after disable", throttled, 1'b0);

    // R4: soft reset while throttled
    writeReg(8'h09, 16'h0010, "R1");
    for (int i = 0; i < 8; i++) cycle("R2");
    softRst = 1;
    cycle("R4");
    chk("R4", "throttled cleared", throttled, 1'b0);
    softRst = 0;
    for (int i = 0; i < 10; i++) cycle("R4");

    // R9: hard reset mid-run
    writeReg(8'h09, 16'h0010, "R1");
    for (int i = 0; i < 7; i++) cycle("R2");
    hardReset();
    for (int i = 0; i < 6; i++) cycle("R9");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      idleIn();
      coreBusy    = ($urandom % 10) == 0;
      coreWaiting = ($urandom % 8) != 0;
      if (($urandom % 40) == 0) begin
        wrEn   = 1;
        wrAddr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h09;
        wrData = 16'($urandom);
        if (($urandom % 3) != 0) wrData[4] = 1'b1;
      end
      softRst = ($urandom % 600) == 0;
      cycle(thrM ? "R2" : "R6");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule